// File: doc/BRIEF.md
# Flash Emulation RAM Overlay Controller

This block lets a small window of on-chip RAM take the place of part of the small-block flash region in the CPU address map. Firmware can then develop and test flash update contents in RAM before committing them. A single 8-bit control register on a simple write-strobe register bus holds a two-bit overlay select in its top bits. The remaining six bits are stored and read back for use by neighbouring clock and wait-state logic. The block decodes each 16-bit CPU address in the same cycle. It reports whether the access belongs to flash or RAM and, for overlaid accesses, gives the remapped RAM address.

Two of the select encodings open an overlay at once. While either of them is active, the block refuses flash program and erase requests but still passes verify requests. The third encoding is deferred. It arms the overlay only when an interrupt arrives while the high programming voltage is present, so an interrupt handler can run from RAM during a flash program or erase. The armed state is dropped as soon as the voltage goes away or the encoding changes.

Top module: `ovl_flash_emu`

## Requirements
- R1: A synchronous reset, or the hardware-standby input, loads the control register with 0x08; hardware standby takes priority over a same-cycle write.
- R2: A write strobe stores all eight data bits, and the stored value appears on the read-data output on the following cycle.
- R3: With select bits [7:6] = 00 no overlay exists; flash_sel is high for every address below FLASH_LIMIT (default 0xE000); ram_sel is high only inside the native RAM range RAM_LO..RAM_HI (default 0xF780..0xFF7F); and ram_addr equals the CPU address.
- R4: With select bits = 01, addresses 0x0080..0x00FF set ram_sel, clear flash_sel and give ram_addr = 0xFC80 + (addr - 0x0080); neighbouring addresses route as in R3.
- R5: With select bits = 10, addresses 0x0080..0x017F route to RAM at 0xFC80 + (addr - 0x0080); neighbouring addresses route as in R3.
- R6: With select bits = 11 and the overlay triggered, addresses 0x0000..0x007F route to RAM at 0xFC00 + addr; when not triggered, those addresses route to flash.
- R7: In encoding 11 the overlay triggers on a clock edge at which the interrupt input and the programming-voltage input are both high, and it takes effect from the next cycle; an interrupt with the voltage low does not trigger it.
- R8: Once triggered, the overlay stays on without further interrupts. It is cleared on the edge after the programming voltage goes low, and it is cleared when the select bits leave 11, so a later return to 11 needs a fresh trigger.
- R9: While exactly one select bit is set, prog_allow and erase_allow stay low whatever the program and erase requests are.
- R10: verify_allow always follows the verify request; in encodings 00 and 11, prog_allow and erase_allow follow their requests.
- R11: flash_sel and ram_sel are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby; reloads the control register |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| irq_in | input | 1 | Interrupt indication used to trigger the deferred overlay |
| vpp_hi | input | 1 | High programming voltage present |
| cpu_addr | input | 16 | CPU access address |
| flash_sel | output | 1 | Access goes to flash |
| ram_sel | output | 1 | Access goes to RAM |
| ram_addr | output | 16 | RAM address for the access |
| req_p | input | 1 | Flash program mode request |
| req_e | input | 1 | Flash erase mode request |
| req_v | input | 1 | Flash verify mode request |
| prog_allow | output | 1 | Program request granted |
| erase_allow | output | 1 | Erase request granted |
| verify_allow | output | 1 | Verify request granted |

## Verification
The bench goes after window edges: the first and last address of each window and the address on either side of it, in every encoding. An off-by-one compare would grow or shrink a window, and a wrong base would return RAM addresses shifted by a constant. It walks the deferred encoding through an interrupt with the voltage low, a proper trigger, a voltage drop and a round trip through another encoding. A design that armed without voltage, or that kept a stale trigger, would show the RAM window while flash should still be visible. All request combinations are applied in every encoding, so a protect that leaked into encoding 11, or that also blocked verify, would show up as a wrong grant.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W = 16;
    localparam int CTL_W  = 8;
    localparam logic [CTL_W-1:0] CTL_RESET = 8'h08;

    // Overlay select encoding; bit order {bit7, bit6} is behaviour.
    typedef enum logic [1:0] {
        OVL_OFF    = 2'b00,
        OVL_NARROW = 2'b01,
        OVL_WIDE   = 2'b10,
        OVL_DEFER  = 2'b11
    } ovl_mode_e;

    // Control register layout.
    typedef struct packed {
        ovl_mode_e  mode;       // [7:6]
        logic       clk_dbl;    // [5]
        logic       spare;      // [4]
        logic [1:0] wait_mode;  // [3:2]
        logic [1:0] wait_cnt;   // [1:0]
    } ctl_reg_t;

    // One overlay window: flash-side base, length, RAM-side base.
    typedef struct packed {
        logic [ADDR_W-1:0] flash_base;
        logic [ADDR_W-1:0] span;
        logic [ADDR_W-1:0] ram_base;
    } window_t;

    typedef struct packed {
        logic              flash_sel;
        logic              ram_sel;
        logic [ADDR_W-1:0] ram_addr;
    } route_t;

    typedef struct packed {
        logic p;
        logic e;
        logic v;
    } flash_req_t;

    function automatic window_t window_of(ovl_mode_e m);
        window_t w;
        unique case (m)
            OVL_NARROW: w = '{flash_base: 16'h0080, span: 16'h0080, ram_base: 16'hFC80};
            OVL_WIDE:   w = '{flash_base: 16'h0080, span: 16'h0100, ram_base: 16'hFC80};
            OVL_DEFER:  w = '{flash_base: 16'h0000, span: 16'h0080, ram_base: 16'hFC00};
            default:    w = '{flash_base: 16'h0000, span: 16'h0000, ram_base: 16'h0000};
        endcase
        return w;
    endfunction

    function automatic logic in_window(logic [ADDR_W-1:0] a, window_t w);
        logic [ADDR_W-1:0] off;
        off = a - w.flash_base;
        return (a >= w.flash_base) && (off < w.span);
    endfunction

    function automatic logic single_select(ovl_mode_e m);
        return (m == OVL_NARROW) || (m == OVL_WIDE);
    endfunction

endpackage

// File: rtl/ovl_ctl_reg.sv
module ovl_ctl_reg
    import ovl_pkg::*;
#(
    parameter logic [CTL_W-1:0] RESET_VAL = CTL_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_stby,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_reg_t         ctl_q
);

    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            ctl_q <= ctl_reg_t'(RESET_VAL);
        end else if (wr) begin
            ctl_q <= ctl_reg_t'(wdata);
        end
    end

endmodule

// File: rtl/ovl_arm.sv
module ovl_arm
    import ovl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ovl_mode_e mode,
    input  logic      irq_in,
    input  logic      vpp_hi,
    output logic      trig_q
);

    logic deferred;
    logic trig_d;

    always_comb begin
        deferred = (mode == OVL_DEFER);
        // Hold while voltage stays and the deferred encoding is kept;
        // set only by an interrupt seen with voltage present.
        trig_d   = deferred && vpp_hi && (trig_q || irq_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_d;
        end
    end

endmodule

// File: rtl/ovl_route.sv
module ovl_route
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FLASH_LIMIT = 16'hE000,
    parameter logic [ADDR_W-1:0] RAM_LO      = 16'hF780,
    parameter logic [ADDR_W-1:0] RAM_HI      = 16'hFF7F
) (
    input  ovl_mode_e         mode,
    input  logic              trig,
    input  logic [ADDR_W-1:0] addr,
    output route_t            route
);

    window_t           win;
    logic              live;
    logic              hit;
    logic              native_ram;
    logic              native_flash;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        win          = window_of(mode);
        live         = (mode != OVL_OFF) && ((mode != OVL_DEFER) || trig);
        hit          = live && in_window(addr, win);
        offset       = addr - win.flash_base;
        native_ram   = (addr >= RAM_LO) && (addr <= RAM_HI);
        native_flash = (addr < FLASH_LIMIT);

        route.flash_sel = native_flash && !hit;
        route.ram_sel   = hit || native_ram;
        route.ram_addr  = hit ? (win.ram_base + offset) : addr;
    end

endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
    import ovl_pkg::*;
(
    input  ovl_mode_e  mode,
    input  flash_req_t req,
    output flash_req_t grant
);

    localparam int N_LANES = 2;  // program and erase are gated alike

    logic               protect;
    logic [N_LANES-1:0] lane_req;
    logic [N_LANES-1:0] lane_gnt;

    assign protect  = single_select(mode);
    assign lane_req = {req.e, req.p};

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign lane_gnt[i] = lane_req[i] && !protect;
    end

    assign grant.p = lane_gnt[0];
    assign grant.e = lane_gnt[1];
    assign grant.v = req.v;

endmodule

// File: rtl/ovl_flash_emu.sv
module ovl_flash_emu
    import ovl_pkg::*;
#(
    parameter logic [15:0] FLASH_LIMIT = 16'hE000,
    parameter logic [15:0] RAM_LO      = 16'hF780,
    parameter logic [15:0] RAM_HI      = 16'hFF7F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hw_stby,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        irq_in,
    input  logic        vpp_hi,
    input  logic [15:0] cpu_addr,
    output logic        flash_sel,
    output logic        ram_sel,
    output logic [15:0] ram_addr,
    input  logic        req_p,
    input  logic        req_e,
    input  logic        req_v,
    output logic        prog_allow,
    output logic        erase_allow,
    output logic        verify_allow
);

    ctl_reg_t   ctl_q;
    logic       trig_q;
    route_t     route;
    flash_req_t req;
    flash_req_t grant;

    ovl_ctl_reg #(.RESET_VAL(CTL_RESET)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .hw_stby(hw_stby),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .ctl_q  (ctl_q)
    );

    ovl_arm u_arm (
        .clk   (clk),
        .rst   (rst),
        .mode  (ctl_q.mode),
        .irq_in(irq_in),
        .vpp_hi(vpp_hi),
        .trig_q(trig_q)
    );

    ovl_route #(
        .FLASH_LIMIT(FLASH_LIMIT),
        .RAM_LO     (RAM_LO),
        .RAM_HI     (RAM_HI)
    ) u_route (
        .mode (ctl_q.mode),
        .trig (trig_q),
        .addr (cpu_addr),
        .route(route)
    );

    assign req = '{p: req_p, e: req_e, v: req_v};

    ovl_guard u_guard (
        .mode (ctl_q.mode),
        .req  (req),
        .grant(grant)
    );

    assign reg_rdata    = ctl_q;
    assign flash_sel    = route.flash_sel;
    assign ram_sel      = route.ram_sel;
    assign ram_addr     = route.ram_addr;
    assign prog_allow   = grant.p;
    assign erase_allow  = grant.e;
    assign verify_allow = grant.v;

endmodule

// File: rtl/ovl_flash_emu_chk.sv
module ovl_flash_emu_chk (
    input logic        clk,
    input logic        rst,
    input logic        hw_stby,
    input logic        reg_wr,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  reg_rdata,
    input logic        vpp_hi,
    input logic [15:0] cpu_addr,
    input logic        flash_sel,
    input logic        ram_sel,
    input logic        req_p,
    input logic        req_e,
    input logic        req_v,
    input logic        prog_allow,
    input logic        erase_allow,
    input logic        verify_allow
);

    logic [1:0] sel;
    assign sel = reg_rdata[7:6];

    // R1
    a_r1_standby_value: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> reg_rdata == 8'h08);

    // R2
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !hw_stby) |=> reg_rdata == $past(reg_wdata));

    // R4
    a_r4_narrow_hits_ram: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b01 && cpu_addr >= 16'h0080 && cpu_addr <= 16'h00FF)
            |-> (ram_sel && !flash_sel));

    // R8
    a_r8_voltage_drop: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b11 && !vpp_hi && !reg_wr && !hw_stby)
            |=> !(cpu_addr <= 16'h007F && ram_sel));

    // R9
    a_r9_protect: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b01 || sel == 2'b10) |-> (!prog_allow && !erase_allow));

    // R10
    a_r10_verify_passes: assert property (@(posedge clk) disable iff (rst)
        verify_allow == req_v);

    // R11
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flash_sel && ram_sel));

    // R10 (encodings without protection)
    a_r10_pe_follow: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b00 || sel == 2'b11) |-> (prog_allow == req_p && erase_allow == req_e));

endmodule

bind ovl_flash_emu ovl_flash_emu_chk u_chk (.*);

// File: tb/ovl_flash_emu_test.sv
`timescale 1ns/100ps
module ovl_flash_emu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_stby = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq_in = 1'b0;
    logic        vpp_hi = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        flash_sel;
    logic        ram_sel;
    logic [15:0] ram_addr;
    logic        req_p = 1'b0;
    logic        req_e = 1'b0;
    logic        req_v = 1'b0;
    logic        prog_allow;
    logic        erase_allow;
    logic        verify_allow;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ovl_flash_emu uut (
        .clk(clk), .rst(rst), .hw_stby(hw_stby),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .vpp_hi(vpp_hi), .cpu_addr(cpu_addr),
        .flash_sel(flash_sel), .ram_sel(ram_sel), .ram_addr(ram_addr),
        .req_p(req_p), .req_e(req_e), .req_v(req_v),
        .prog_allow(prog_allow), .erase_allow(erase_allow), .verify_allow(verify_allow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected routing for a select encoding and trigger state.
    task automatic check_route(input logic [1:0] m, input bit trig,
                               input logic [15:0] a, input string req);
        int lo;
        int len;
        int rb;
        bit hit;
        logic [15:0] ea;
        bit ef;
        bit er;
        lo = 0; len = 0; rb = 0;
        case (m)
            2'b01: begin lo = 'h80; len = 'h80;  rb = 'hFC80; end
            2'b10: begin lo = 'h80; len = 'h100; rb = 'hFC80; end
            2'b11: begin lo = 'h00; len = trig ? 'h80 : 0; rb = 'hFC00; end
            default: ;
        endcase
        hit = (int'(a) >= lo) && (int'(a) < lo + len);
        ea  = hit ? 16'(rb + int'(a) - lo) : a;
        ef  = !hit && (a < 16'hE000);
        er  = hit || (a >= 16'hF780 && a <= 16'hFF7F);
        cpu_addr = a;
        #0.1;
        check({flash_sel, ram_sel, ram_addr} == {ef, er, ea}, req,
              {14'd0, flash_sel, ram_sel, ram_addr}, {14'd0, ef, er, ea});
    endtask

    task automatic sweep(input logic [1:0] m, input bit trig, input string req);
        logic [15:0] edges [6] = '{16'hDFFF, 16'hE000, 16'hF77F, 16'hF780, 16'hFF7F, 16'hFF80};
        for (int a = 0; a < 'h200; a++) check_route(m, trig, 16'(a), req);
        foreach (edges[i]) check_route(m, trig, edges[i], req);
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #0.5;
    endtask

    task automatic check_grants(input logic [1:0] m);
        bit prot;
        prot = (m == 2'b01) || (m == 2'b10);
        for (int r = 0; r < 8; r++) begin
            {req_p, req_e, req_v} = 3'(r);
            #0.1;
            check(prog_allow == (req_p && !prot) && erase_allow == (req_e && !prot),
                  prot ? "R9" : "R10", {prog_allow, erase_allow},
                  {req_p && !prot, req_e && !prot});
            check(verify_allow == req_v, "R10", verify_allow, req_v);
        end
        {req_p, req_e, req_v} = 3'b000;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        check(reg_rdata == 8'h08, "R1", reg_rdata, 8'h08);
        sweep(2'b00, 1'b0, "R3");
        check_grants(2'b00);

        // Each encoding: readback, routing, grants.
        for (int m = 0; m < 4; m++) begin
            logic [7:0] d;
            d = {2'(m), 6'h2D};
            write_reg(d);
            check(reg_rdata == d, "R2", reg_rdata, d);
            sweep(2'(m), 1'b0, m == 1 ? "R4" : m == 2 ? "R5" : m == 3 ? "R6" : "R3");
            check_grants(2'(m));
        end

        // Deferred encoding: interrupt without voltage does not trigger.
        @(negedge clk);
        irq_in = 1'b1;
        @(negedge clk);
        irq_in = 1'b0;
        #0.5;
        check_route(2'b11, 1'b0, 16'h0010, "R7");

        // Proper trigger.
        vpp_hi = 1'b1;
        @(negedge clk);
        check_route(2'b11, 1'b0, 16'h0000, "R7");
        irq_in = 1'b1;
        @(negedge clk);
        irq_in = 1'b0;
        #0.5;
        check_route(2'b11, 1'b1, 16'h0000, "R7");
        repeat (4) @(negedge clk);
        sweep(2'b11, 1'b1, "R6");
        check_route(2'b11, 1'b1, 16'h007F, "R8");

        // Voltage drop clears.
        @(negedge clk);
        vpp_hi = 1'b0;
        @(negedge clk);
        vpp_hi = 1'b1;
        #0.5;
        check_route(2'b11, 1'b0, 16'h0040, "R8");

        // Re-trigger, leave and return: needs a fresh trigger.
        @(negedge clk);
        irq_in = 1'b1;
        @(negedge clk);
        irq_in = 1'b0;
        #0.5;
        check_route(2'b11, 1'b1, 16'h0040, "R7");
        write_reg(8'h40);
        check_route(2'b01, 1'b0, 16'h0040, "R8");
        @(negedge clk);
        write_reg(8'hC0);
        check_route(2'b11, 1'b0, 16'h0040, "R8");
        check_grants(2'b11);

        // Hardware standby wins over a same-cycle write.
        @(negedge clk);
        hw_stby = 1'b1;
        reg_wr = 1'b1;
        reg_wdata = 8'hFF;
        @(negedge clk);
        hw_stby = 1'b0;
        reg_wr = 1'b0;
        #0.5;
        check(reg_rdata == 8'h08, "R1", reg_rdata, 8'h08);
        check_route(2'b00, 1'b0, 16'h0090, "R3");

        // Synchronous reset after a write.
        write_reg(8'h97);
        check(reg_rdata == 8'h97, "R2", reg_rdata, 8'h97);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check(reg_rdata == 8'h08, "R1", reg_rdata, 8'h08);
        check(!(flash_sel && ram_sel), "R11", {flash_sel, ram_sel}, 2'b00);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule